// File: doc/BRIEF.md
# Bit-Time Timestamp Counter with Frame Capture

This block keeps a 16-bit timestamp measured in protocol bit times. The protocol core sends a one-cycle strobe for each bit time. A programmable divider turns every N of these strobes into one count step, with N from 1 to 16. The counter runs freely and rolls over to zero after its maximum value. Each rollover raises a sticky flag that software must acknowledge.

When the protocol core signals the start of a frame, the block copies the current count to one of two outputs. A receive frame goes to the receive timestamp output, and a transmit frame goes to the transmit-event timestamp output. The chosen output also gives a one-cycle valid strobe, so the storage logic next to the block can write the value into its buffer element.

A small register port gives access to three registers: configuration, counter value and flag. A source-select field in the configuration either runs the counter or holds it, and every captured stamp, at zero.

Top module: `tstamp_unit`

## Requirements
- R1: After reset, the count is 0, the wrap flag is clear, both valid strobes are low, and the configuration register reads 0 (source held at zero).
- R2: The configuration register sits at address 0. Bits [3:0] hold the prescale P and bits [5:4] hold the source select. With source select 2'b01, the count advances by one on every (P+1)-th bit-time strobe.
- R3: When an advance takes the count past 16'hFFFF, the count becomes 0. The wrap flag (address 2, bit 0, also driven on `wrap_irq`) is set on that same clock edge.
- R4: The wrap flag stays set until a write to address 2 with data bit 0 = 1. A write with bit 0 = 0 leaves it unchanged. A wrap in the same cycle as a clearing write leaves the flag set.
- R5: Any write to address 1 sets the count to 0, whatever the data.
- R6: With a source select other than 2'b01, the count and the prescale divider are held at 0, and captured stamps are 0.
- R7: A configuration write that changes P restarts the divider, so the next advance comes after P+1 fresh strobes.
- R8: A start-of-frame pulse with `sof_is_tx`=0 loads the count into `rx_ts` and raises `rx_ts_vld` for exactly one cycle. If an advance happens in the same cycle, the value loaded is the count before that advance.
- R9: A start-of-frame pulse with `sof_is_tx`=1 does the same through `tx_ts` and `tx_ts_vld`. The receive outputs are left unchanged.
- R10: `reg_rdata` returns {10'b0, select, P} at address 0, the count at address 1, {15'b0, flag} at address 2, and 0 at address 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | One-cycle strobe per protocol bit time |
| sof_pulse | input | 1 | Start-of-frame event |
| sof_is_tx | input | 1 | Tags the event: 1 = transmit, 0 = receive |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, combinational from `reg_addr` |
| count_o | output | 16 | Current timestamp count |
| wrap_irq | output | 1 | Sticky wrap flag |
| rx_ts | output | 16 | Last receive timestamp |
| rx_ts_vld | output | 1 | One-cycle strobe for a new `rx_ts` |
| tx_ts | output | 16 | Last transmit-event timestamp |
| tx_ts_vld | output | 1 | One-cycle strobe for a new `tx_ts` |

## Verification
The assertions assume that `bit_tick` and `sof_pulse` are single-cycle strobes sampled on the clock edge. They also assume that a register write lasts exactly one cycle. The bench drives every input on the falling edge and holds each strobe for a single cycle, except in the rollover run, where `bit_tick` is intentionally held high on every cycle. The bench puts a clearing write in the same cycle as the rollover advance. It does not combine a prescale change with a strobe in the same cycle, because that case is left to the design's priority rule.

// File: rtl/tsu_pkg.sv
package tsu_pkg;
  localparam int TS_W   = 16;
  localparam int PSC_W  = 4;
  localparam int SEL_W  = 2;
  localparam int ADR_W  = 2;

  localparam logic [ADR_W-1:0] A_CFG  = 2'd0;
  localparam logic [ADR_W-1:0] A_CNT  = 2'd1;
  localparam logic [ADR_W-1:0] A_FLAG = 2'd2;

  typedef enum logic [SEL_W-1:0] {
    SRC_ZERO  = 2'b00,
    SRC_COUNT = 2'b01,
    SRC_RSV2  = 2'b10,
    SRC_RSV3  = 2'b11
  } ts_src_e;
endpackage

// File: rtl/tsu_cfg.sv
module tsu_cfg #(
  parameter int PSC_W = 4,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [PSC_W-1:0] psc_wd,
  input  logic [SEL_W-1:0] sel_wd,
  output logic [PSC_W-1:0] psc_q,
  output logic [SEL_W-1:0] sel_q,
  output logic             en_q,
  output logic             en_n,
  output logic             psc_chg
);
  import tsu_pkg::*;

  logic [PSC_W-1:0] psc_n;
  logic [SEL_W-1:0] sel_n;

  always_comb begin
    psc_n = psc_q;
    sel_n = sel_q;
    if (cfg_we) begin
      psc_n = psc_wd;
      sel_n = sel_wd;
    end
    psc_chg = cfg_we && (psc_wd != psc_q);
    en_n    = (sel_n == SEL_W'(SRC_COUNT));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psc_q <= '0;
      sel_q <= '0;
      en_q  <= 1'b0;
    end else begin
      psc_q <= psc_n;
      sel_q <= sel_n;
      en_q  <= en_n;
    end
  end
endmodule

// File: rtl/tsu_divider.sv
module tsu_divider #(
  parameter int PSC_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_q,
  input  logic             en_n,
  input  logic             restart,
  input  logic             bit_tick,
  input  logic [PSC_W-1:0] psc,
  output logic             inc
);
  logic [PSC_W-1:0] div_q, div_n;
  logic             last;

  always_comb begin
    last  = (div_q == psc);
    inc   = en_q && bit_tick && !restart && last;
    div_n = div_q;
    if (!en_n || restart)
      div_n = '0;
    else if (bit_tick)
      div_n = last ? '0 : div_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_n;
  end
endmodule

// File: rtl/tsu_counter.sv
module tsu_counter #(
  parameter int TS_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en_n,
  input  logic            clr,
  input  logic            inc,
  input  logic            flag_clr,
  output logic [TS_W-1:0] cnt_q,
  output logic            flag_q
);
  localparam logic [TS_W-1:0] MAXV = '1;

  logic [TS_W-1:0] cnt_n;
  logic            wrap, flag_n;

  always_comb begin
    wrap  = inc && (cnt_q == MAXV);
    cnt_n = cnt_q;
    if (!en_n || clr) cnt_n = '0;
    else if (inc)     cnt_n = cnt_q + 1'b1;
    flag_n = flag_q;
    if (wrap)          flag_n = 1'b1;
    else if (flag_clr) flag_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_n;
      flag_q <= flag_n;
    end
  end
endmodule

// File: rtl/tsu_capture.sv
module tsu_capture #(
  parameter int TS_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            take,
  input  logic [TS_W-1:0] val,
  output logic [TS_W-1:0] ts_q,
  output logic            vld_q
);
  logic [TS_W-1:0] ts_n;

  always_comb ts_n = take ? val : ts_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ts_q  <= '0;
      vld_q <= 1'b0;
    end else begin
      ts_q  <= ts_n;
      vld_q <= take;
    end
  end
endmodule

// File: rtl/tstamp_unit.sv
module tstamp_unit
  import tsu_pkg::*;
#(
  parameter int TSW = TS_W,
  parameter int PW  = PSC_W,
  parameter int SW  = SEL_W,
  parameter int AW  = ADR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_tick,
  input  logic          sof_pulse,
  input  logic          sof_is_tx,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [15:0]   reg_wdata,
  output logic [15:0]   reg_rdata,
  output logic [TSW-1:0] count_o,
  output logic          wrap_irq,
  output logic [TSW-1:0] rx_ts,
  output logic          rx_ts_vld,
  output logic [TSW-1:0] tx_ts,
  output logic          tx_ts_vld
);
  localparam int CFG_W = PW + SW;

  logic [PW-1:0] psc_q;
  logic [SW-1:0] sel_q;
  logic          en_q, en_n, psc_chg, inc;
  logic          cfg_we, cnt_clr, flag_clr;
  logic          take_rx, take_tx;
  logic [TSW-1:0] cnt_q;
  logic          flag_q;
  logic          unused_wdata;

  assign cfg_we   = reg_wr && (reg_addr == A_CFG);
  assign cnt_clr  = reg_wr && (reg_addr == A_CNT);
  assign flag_clr = reg_wr && (reg_addr == A_FLAG) && reg_wdata[0];
  assign take_rx  = sof_pulse && !sof_is_tx;
  assign take_tx  = sof_pulse && sof_is_tx;
  assign unused_wdata = ^reg_wdata[15:CFG_W];

  tsu_cfg #(.PSC_W(PW), .SEL_W(SW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we),
    .psc_wd(reg_wdata[PW-1:0]), .sel_wd(reg_wdata[CFG_W-1:PW]),
    .psc_q(psc_q), .sel_q(sel_q), .en_q(en_q), .en_n(en_n), .psc_chg(psc_chg)
  );

  tsu_divider #(.PSC_W(PW)) u_div (
    .clk(clk), .rst_n(rst_n), .en_q(en_q), .en_n(en_n), .restart(psc_chg),
    .bit_tick(bit_tick), .psc(psc_q), .inc(inc)
  );

  tsu_counter #(.TS_W(TSW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .en_n(en_n), .clr(cnt_clr), .inc(inc),
    .flag_clr(flag_clr), .cnt_q(cnt_q), .flag_q(flag_q)
  );

  tsu_capture #(.TS_W(TSW)) u_cap_rx (
    .clk(clk), .rst_n(rst_n), .take(take_rx), .val(cnt_q),
    .ts_q(rx_ts), .vld_q(rx_ts_vld)
  );

  tsu_capture #(.TS_W(TSW)) u_cap_tx (
    .clk(clk), .rst_n(rst_n), .take(take_tx), .val(cnt_q),
    .ts_q(tx_ts), .vld_q(tx_ts_vld)
  );

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CFG:   reg_rdata[CFG_W-1:0] = {sel_q, psc_q};
      A_CNT:   reg_rdata[TSW-1:0]   = cnt_q;
      A_FLAG:  reg_rdata[0]         = flag_q;
      default: reg_rdata = '0;
    endcase
  end

  assign count_o  = cnt_q;
  assign wrap_irq = flag_q;
endmodule

// File: rtl/tsu_checker.sv
module tsu_checker #(
  parameter int TSW = 16,
  parameter int AW  = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic           reg_wr,
  input logic [AW-1:0]  reg_addr,
  input logic [15:0]    reg_wdata,
  input logic           sof_pulse,
  input logic           sof_is_tx,
  input logic           inc,
  input logic           en_q,
  input logic [TSW-1:0] count_o,
  input logic           wrap_irq,
  input logic [TSW-1:0] rx_ts,
  input logic           rx_ts_vld,
  input logic [TSW-1:0] tx_ts,
  input logic           tx_ts_vld
);
  localparam logic [TSW-1:0] TOP = '1;

  AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && inc && count_o != TOP && !(reg_wr && reg_addr == 2'd1) && !(reg_wr && reg_addr == 2'd0))
      |=> count_o == $past(count_o) + 1'b1); // R2

  AST_WRAP_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && count_o == TOP) |=> wrap_irq); // R3

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap_irq && !(reg_wr && reg_addr == 2'd2 && reg_wdata[0])) |=> wrap_irq); // R4

  AST_CLEAR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd1) |=> count_o == '0); // R5

  AST_HELD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |-> count_o == '0); // R6

  AST_RX_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (sof_pulse && !sof_is_tx) |=> (rx_ts_vld && rx_ts == $past(count_o))); // R8

  AST_RX_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ts_vld |-> $past(sof_pulse && !sof_is_tx)); // R8

  AST_TX_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (sof_pulse && sof_is_tx) |=> (tx_ts_vld && tx_ts == $past(count_o) && $stable(rx_ts))); // R9

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !(rx_ts_vld && tx_ts_vld)); // R9
endmodule

bind tstamp_unit tsu_checker #(.TSW(TSW), .AW(AW)) i_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .sof_pulse(sof_pulse), .sof_is_tx(sof_is_tx),
  .inc(inc), .en_q(en_q), .count_o(count_o), .wrap_irq(wrap_irq),
  .rx_ts(rx_ts), .rx_ts_vld(rx_ts_vld), .tx_ts(tx_ts), .tx_ts_vld(tx_ts_vld)
);

// File: tb/test_tstamp_unit.sv
module test_tstamp_unit;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 7;
  // {prescale, ticks, expected count}
  localparam logic [3:0]  V_PSC [NVEC] = '{4'd0, 4'd1, 4'd3, 4'd15, 4'd15, 4'd2, 4'd7};
  localparam int          V_TCK [NVEC] = '{5, 7, 8, 33, 15, 9, 23};
  localparam logic [15:0] V_EXP [NVEC] = '{16'd5, 16'd3, 16'd2, 16'd2, 16'd0, 16'd3, 16'd2};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_tick = 1'b0, sof_pulse = 1'b0, sof_is_tx = 1'b0, reg_wr = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata, count_o, rx_ts, tx_ts;
  logic wrap_irq, rx_ts_vld, tx_ts_vld;
  int errors = 0, checks = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tstamp_unit i_tstamp_unit (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .sof_pulse(sof_pulse),
    .sof_is_tx(sof_is_tx), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .count_o(count_o),
    .wrap_irq(wrap_irq), .rx_ts(rx_ts), .rx_ts_vld(rx_ts_vld),
    .tx_ts(tx_ts), .tx_ts_vld(tx_ts_vld)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      bit_tick = 1'b1;
      @(negedge clk);
      bit_tick = 1'b0;
    end
  endtask

  task automatic sof(input logic tx);
    sof_pulse = 1'b1; sof_is_tx = tx;
    @(negedge clk);
    sof_pulse = 1'b0; sof_is_tx = 1'b0;
  endtask

  initial begin
    logic [15:0] r;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 count", count_o, 16'h0);
    chk("R1 flag", {15'b0, wrap_irq}, 16'h0);
    chk("R1 strobes", {14'b0, rx_ts_vld, tx_ts_vld}, 16'h0);
    rd(2'd0, r); chk("R1 cfg", r, 16'h0);

    // R2 table of prescale vectors
    for (int v = 0; v < NVEC; v++) begin
      wr(2'd0, 16'h0000);
      wr(2'd0, {10'b0, 2'b01, V_PSC[v]});
      ticks(V_TCK[v]);
      chk($sformatf("R2 vec%0d", v), count_o, V_EXP[v]);
    end

    // R10 read mux
    rd(2'd0, r); chk("R10 cfg", r, 16'h0017);
    rd(2'd1, r); chk("R10 cnt", r, 16'h0002);
    rd(2'd3, r); chk("R10 rsvd", r, 16'h0000);

    // R5 write of any data clears the count
    wr(2'd1, 16'hABCD);
    chk("R5 clear", count_o, 16'h0);

    // R7 prescale change restarts the divider
    wr(2'd0, 16'h0000);
    wr(2'd0, 16'h0013);
    ticks(2);
    wr(2'd0, 16'h0011);
    ticks(2);
    chk("R7 restart", count_o, 16'h1);

    // R8 rx capture, same-cycle advance records the earlier value
    wr(2'd0, 16'h0000);
    wr(2'd0, 16'h0010);
    ticks(5);
    bit_tick = 1'b1; sof_pulse = 1'b1; sof_is_tx = 1'b0;
    @(negedge clk);
    bit_tick = 1'b0; sof_pulse = 1'b0;
    chk("R8 rx value", rx_ts, 16'h5);
    chk("R8 rx vld", {15'b0, rx_ts_vld}, 16'h1);
    chk("R8 count advanced", count_o, 16'h6);
    @(negedge clk);
    chk("R8 vld one cycle", {15'b0, rx_ts_vld}, 16'h0);

    // R9 tx capture leaves rx untouched
    ticks(3);
    sof(1'b1);
    chk("R9 tx value", tx_ts, 16'h9);
    chk("R9 tx vld", {14'b0, tx_ts_vld, rx_ts_vld}, 16'h2);
    chk("R9 rx kept", rx_ts, 16'h5);
    @(negedge clk);
    chk("R9 vld one cycle", {15'b0, tx_ts_vld}, 16'h0);

    // R6 other select values hold at zero
    wr(2'd0, 16'h0020);
    ticks(5);
    chk("R6 held", count_o, 16'h0);
    sof(1'b1);
    chk("R6 tx zero", tx_ts, 16'h0);
    wr(2'd0, 16'h0030);
    ticks(3);
    chk("R6 sel3 held", count_o, 16'h0);

    // R3 and R4: run to the top, wrap together with a clearing write
    wr(2'd0, 16'h0010);
    bit_tick = 1'b1;
    repeat (65535) @(negedge clk);
    chk("R2 reach max", count_o, 16'hFFFF);
    chk("R3 no flag yet", {15'b0, wrap_irq}, 16'h0);
    reg_wr = 1'b1; reg_addr = 2'd2; reg_wdata = 16'h0001;
    @(negedge clk);
    bit_tick = 1'b0; reg_wr = 1'b0;
    chk("R3 wrapped", count_o, 16'h0);
    chk("R4 wrap beats clear", {15'b0, wrap_irq}, 16'h1);
    wr(2'd2, 16'hFFFE);
    rd(2'd2, r); chk("R4 zero write ignored", r, 16'h1);
    wr(2'd2, 16'h0001);
    chk("R4 cleared", {15'b0, wrap_irq}, 16'h0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule